// File: doc/BRIEF.md
# Dual-Port Contention Arbiter

This block sits beside a two-port shared memory array and decides which port may use a word when both ports select it at once. Every cycle it compares the two ports' enables and addresses. When both ports are enabled on the same word, the port that was already there keeps the word. The other port sees its active-low busy flag go low, and its write strobe toward the array is withheld. Reads by the losing port are not affected, so no read data path passes through the block.

A mode input selects one of two roles. In master mode the arbiter computes the busy flags itself and drives them out. Several devices that widen the data word can then share one decision. In slave mode the arbiter stops deciding. It takes the busy flags from a master as inputs and uses them only to block local writes. Its own busy outputs stay inactive in this mode.

The decision is combinational on the current inputs plus a small amount of registered history. For each port the history records whether the port was enabled on the same address at the previous clock edge. A registered winner flag holds the outcome for as long as the contention lasts.

Top module: `dpram_contention_arbiter`

## Requirements
- R1: While reset is high and in the cycle after it, with both ports idle, both busy outputs are high (inactive) and both write permits are low.
- R2: In master mode, when either enable is low or the two addresses differ, both busy outputs are high.
- R3: In master mode, a port that was enabled on an address at the previous clock edge keeps it when the other port's address changes to match. The other port's busy output goes low in that same cycle.
- R4: In master mode, when both addresses already match and one port was enabled at the previous edge, a later enable from the other port makes that later port busy.
- R5: In master mode, when both ports reach the same word in the same cycle, the left port wins and only the right busy output goes low. The two busy outputs are never low together.
- R6: While contention continues over consecutive cycles, the busy output that went low stays low and the winner does not change.
- R7: When contention ends, whether by address mismatch or by either enable dropping, both busy outputs return high in that same cycle. A later contention is decided afresh.
- R8: The write permit of a port is high only when that port's enable and write request are high and its effective busy is high. In master mode the effective busy is the generated flag, so a losing port's write is suppressed.
- R9: In slave mode both busy outputs stay high and the write permit of each port is gated by that port's busy input (low = blocked).
- R10: In slave mode, matching addresses on both enabled ports do not block any write when both busy inputs are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| is_master | input | 1 | 1 = generate busy flags, 0 = take them from busy inputs |
| lt_en | input | 1 | Left port enable, active high |
| lt_wr | input | 1 | Left port write request |
| lt_addr | input | ADDR_W | Left port word address |
| rt_en | input | 1 | Right port enable, active high |
| rt_wr | input | 1 | Right port write request |
| rt_addr | input | ADDR_W | Right port word address |
| lt_busy_in_n | input | 1 | Left busy from a master, active low (slave mode) |
| rt_busy_in_n | input | 1 | Right busy from a master, active low (slave mode) |
| lt_busy_n | output | 1 | Left busy flag, active low |
| rt_busy_n | output | 1 | Right busy flag, active low |
| lt_wr_ok | output | 1 | Left write strobe permit toward the array |
| rt_wr_ok | output | 1 | Right write strobe permit toward the array |

## Verification
The bench builds the arbiter with a 3-bit address. That makes all 64 address pairs times 4 enable combinations reachable as a full sweep of simultaneous arrivals, each checked against an arithmetic prediction. With the same small address space the bench also walks every address through address-first, enable-first and release-then-return orderings for both ports. The slave mode is swept over all busy-input and write-request combinations on matching addresses.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

    typedef enum logic [1:0] {
        WIN_NONE  = 2'd0,
        WIN_LEFT  = 2'd1,
        WIN_RIGHT = 2'd2
    } win_e;

    localparam int NUM_PORTS = 2;
    localparam int LEFT      = 0;
    localparam int RIGHT     = 1;

    typedef struct packed {
        logic en;
        logic wr;
        logic busy_in_n;
    } port_ctl_t;

    // Choose a winner for a new contention from the per-port history.
    function automatic win_e first_arrival(input logic l_settled, input logic r_settled);
        if (r_settled && !l_settled)
            return WIN_RIGHT;
        return WIN_LEFT;
    endfunction

    // Port p loses when the other port holds the word.
    function automatic logic port_loses(input int p, input win_e w);
        if (p == LEFT)
            return (w == WIN_RIGHT);
        return (w == WIN_LEFT);
    endfunction

endpackage

// File: rtl/dpa_port_track.sv
module dpa_port_track #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic              settled
);
    logic              en_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            addr_q <= '0;
        end else begin
            en_q   <= en;
            addr_q <= addr;
        end
    end

    // Port was on this same word at the previous edge.
    assign settled = en && en_q && (addr_q == addr);
endmodule

// File: rtl/dpa_winner.sv
module dpa_winner
    import dpa_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic is_master,
    input  logic match,
    input  logic l_settled,
    input  logic r_settled,
    output win_e decision
);
    win_e win_q;

    always_comb begin
        decision = WIN_NONE;
        if (is_master && match) begin
            if (win_q != WIN_NONE)
                decision = win_q;
            else
                decision = first_arrival(l_settled, r_settled);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            win_q <= WIN_NONE;
        else
            win_q <= decision;
    end
endmodule

// File: rtl/dpa_gate.sv
module dpa_gate
    import dpa_pkg::*;
(
    input  logic                      is_master,
    input  win_e                      decision,
    input  port_ctl_t [NUM_PORTS-1:0] ctl,
    output logic      [NUM_PORTS-1:0] busy_n,
    output logic      [NUM_PORTS-1:0] wr_ok
);
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic eff_busy_n;
        assign busy_n[p]  = is_master ? !port_loses(p, decision) : 1'b1;
        assign eff_busy_n = is_master ? busy_n[p] : ctl[p].busy_in_n;
        assign wr_ok[p]   = ctl[p].en && ctl[p].wr && eff_busy_n;
    end
endmodule

// File: rtl/dpram_contention_arbiter.sv
module dpram_contention_arbiter
    import dpa_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              is_master,
    input  logic              lt_en,
    input  logic              lt_wr,
    input  logic [ADDR_W-1:0] lt_addr,
    input  logic              rt_en,
    input  logic              rt_wr,
    input  logic [ADDR_W-1:0] rt_addr,
    input  logic              lt_busy_in_n,
    input  logic              rt_busy_in_n,
    output logic              lt_busy_n,
    output logic              rt_busy_n,
    output logic              lt_wr_ok,
    output logic              rt_wr_ok
);
    logic [NUM_PORTS-1:0] en_v;
    logic [ADDR_W-1:0]    addr_v [NUM_PORTS];
    logic [NUM_PORTS-1:0] settled_v;
    port_ctl_t [NUM_PORTS-1:0] ctl;
    logic [NUM_PORTS-1:0] busy_v;
    logic [NUM_PORTS-1:0] ok_v;
    logic match;
    win_e decision;

    assign en_v[LEFT]    = lt_en;
    assign en_v[RIGHT]   = rt_en;
    assign addr_v[LEFT]  = lt_addr;
    assign addr_v[RIGHT] = rt_addr;
    assign ctl[LEFT]     = '{en: lt_en, wr: lt_wr, busy_in_n: lt_busy_in_n};
    assign ctl[RIGHT]    = '{en: rt_en, wr: rt_wr, busy_in_n: rt_busy_in_n};

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_track
        dpa_port_track #(.ADDR_W(ADDR_W)) u_track (
            .clk     (clk),
            .rst     (rst),
            .en      (en_v[p]),
            .addr    (addr_v[p]),
            .settled (settled_v[p])
        );
    end

    assign match = &en_v && (addr_v[LEFT] == addr_v[RIGHT]);

    dpa_winner u_winner (
        .clk       (clk),
        .rst       (rst),
        .is_master (is_master),
        .match     (match),
        .l_settled (settled_v[LEFT]),
        .r_settled (settled_v[RIGHT]),
        .decision  (decision)
    );

    dpa_gate u_gate (
        .is_master (is_master),
        .decision  (decision),
        .ctl       (ctl),
        .busy_n    (busy_v),
        .wr_ok     (ok_v)
    );

    assign lt_busy_n = busy_v[LEFT];
    assign rt_busy_n = busy_v[RIGHT];
    assign lt_wr_ok  = ok_v[LEFT];
    assign rt_wr_ok  = ok_v[RIGHT];
endmodule

// File: rtl/dpa_checker.sv
module dpa_checker #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              is_master,
    input logic              lt_en,
    input logic              lt_wr,
    input logic [ADDR_W-1:0] lt_addr,
    input logic              rt_en,
    input logic              rt_wr,
    input logic [ADDR_W-1:0] rt_addr,
    input logic              lt_busy_in_n,
    input logic              rt_busy_in_n,
    input logic              lt_busy_n,
    input logic              rt_busy_n,
    input logic              lt_wr_ok,
    input logic              rt_wr_ok
);
    logic same_word;
    assign same_word = lt_en && rt_en && (lt_addr == rt_addr);

    assert_single_loser_R5: assert property (@(posedge clk) disable iff (rst)
        !(!lt_busy_n && !rt_busy_n));

    assert_idle_not_busy_R2: assert property (@(posedge clk) disable iff (rst)
        (is_master && !same_word) |-> (lt_busy_n && rt_busy_n));

    assert_left_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (is_master && same_word && $past(is_master) && $past(same_word)
         && !$past(rst) && !$past(rt_busy_n)) |-> !rt_busy_n);

    assert_right_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (is_master && same_word && $past(is_master) && $past(same_word)
         && !$past(rst) && !$past(lt_busy_n)) |-> !lt_busy_n);

    assert_left_permit_R8: assert property (@(posedge clk) disable iff (rst)
        lt_wr_ok |-> (lt_en && lt_wr && (is_master ? lt_busy_n : lt_busy_in_n)));

    assert_right_permit_R8: assert property (@(posedge clk) disable iff (rst)
        rt_wr_ok |-> (rt_en && rt_wr && (is_master ? rt_busy_n : rt_busy_in_n)));

    assert_slave_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !is_master |-> (lt_busy_n && rt_busy_n));
endmodule

bind dpram_contention_arbiter dpa_checker #(.ADDR_W(ADDR_W)) u_dpa_checker (
    .clk          (clk),
    .rst          (rst),
    .is_master    (is_master),
    .lt_en        (lt_en),
    .lt_wr        (lt_wr),
    .lt_addr      (lt_addr),
    .rt_en        (rt_en),
    .rt_wr        (rt_wr),
    .rt_addr      (rt_addr),
    .lt_busy_in_n (lt_busy_in_n),
    .rt_busy_in_n (rt_busy_in_n),
    .lt_busy_n    (lt_busy_n),
    .rt_busy_n    (rt_busy_n),
    .lt_wr_ok     (lt_wr_ok),
    .rt_wr_ok     (rt_wr_ok)
);

// File: tb/dpram_contention_arbiter_bench.sv
`timescale 1ns/1ps
module dpram_contention_arbiter_bench;
    localparam int AW = 3;
    localparam int NA = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic is_master = 1'b1;
    logic lt_en = 0, lt_wr = 0, rt_en = 0, rt_wr = 0;
    logic [AW-1:0] lt_addr = '0, rt_addr = '0;
    logic lt_busy_in_n = 1, rt_busy_in_n = 1;
    logic lt_busy_n, rt_busy_n, lt_wr_ok, rt_wr_ok;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dpram_contention_arbiter #(.ADDR_W(AW)) u_dpram_contention_arbiter (
        .clk(clk), .rst(rst), .is_master(is_master),
        .lt_en(lt_en), .lt_wr(lt_wr), .lt_addr(lt_addr),
        .rt_en(rt_en), .rt_wr(rt_wr), .rt_addr(rt_addr),
        .lt_busy_in_n(lt_busy_in_n), .rt_busy_in_n(rt_busy_in_n),
        .lt_busy_n(lt_busy_n), .rt_busy_n(rt_busy_n),
        .lt_wr_ok(lt_wr_ok), .rt_wr_ok(rt_wr_ok)
    );

    // Apply inputs just after a falling edge; outputs settle before the next rising edge.
    task automatic drive(input logic le, input logic [AW-1:0] la, input logic lw,
                         input logic re, input logic [AW-1:0] ra, input logic rw);
        @(negedge clk);
        lt_en = le; lt_addr = la; lt_wr = lw;
        rt_en = re; rt_addr = ra; rt_wr = rw;
        #1;
    endtask

    // Vector order: {lt_busy_n, rt_busy_n, lt_wr_ok, rt_wr_ok}
    task automatic chk(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {lt_busy_n, rt_busy_n, lt_wr_ok, rt_wr_ok};
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b (t=%0t)", req, act, exp, $time);
        end
    endtask

    initial begin
        // R1: reset state
        lt_en = 0; rt_en = 0;
        repeat (3) @(negedge clk);
        #1 chk("R1", 4'b1100);
        @(negedge clk); rst = 0;
        #1 chk("R1", 4'b1100);

        // R5 / R2 / R8: sweep of simultaneous arrivals from an idle cycle
        for (int la = 0; la < NA; la++) begin
            for (int ra = 0; ra < NA; ra++) begin
                for (int c = 0; c < 4; c++) begin
                    logic le, re, m;
                    le = c[0]; re = c[1];
                    m  = le && re && (la == ra);
                    drive(0, '0, 0, 0, '0, 0);
                    drive(le, AW'(la), 1, re, AW'(ra), 1);
                    chk(m ? "R5" : "R2", {1'b1, !m, le, re && !m});
                end
            end
        end

        for (int a = 0; a < NA; a++) begin
            logic [AW-1:0] b;
            b = AW'(a + 1);
            // R3: right sits on word first, left address moves onto it
            drive(0, '0, 0, 0, '0, 0);
            drive(1, b, 1, 1, AW'(a), 1);
            chk("R2", 4'b1111);
            drive(1, AW'(a), 1, 1, AW'(a), 1);
            chk("R3", 4'b0101);
            // R6: held for two more cycles
            drive(1, AW'(a), 1, 1, AW'(a), 1);
            chk("R6", 4'b0101);
            drive(1, AW'(a), 1, 1, AW'(a), 0);
            chk("R6", 4'b0100);
            // R7: right drops enable, release same cycle
            drive(1, AW'(a), 1, 0, AW'(a), 1);
            chk("R7", 4'b1110);
            // R7: right returns; left now settled wins
            drive(1, AW'(a), 1, 1, AW'(a), 1);
            chk("R7", 4'b1010);

            // R3: left first, right address moves onto it
            drive(0, '0, 0, 0, '0, 0);
            drive(1, AW'(a), 1, 1, b, 1);
            chk("R2", 4'b1111);
            drive(1, AW'(a), 1, 1, AW'(a), 1);
            chk("R3", 4'b1010);
            // R7: release by address mismatch
            drive(1, AW'(a), 1, 1, b, 1);
            chk("R7", 4'b1111);

            // R4: right enabled first on matching address, left enables later
            drive(0, '0, 0, 0, '0, 0);
            drive(0, AW'(a), 1, 1, AW'(a), 1);
            chk("R4", 4'b1101);
            drive(1, AW'(a), 1, 1, AW'(a), 1);
            chk("R4", 4'b0101);
            drive(1, AW'(a), 1, 1, AW'(a), 1);
            chk("R6", 4'b0101);
            // R7: winner drops enable, then returns as the later arrival
            drive(1, AW'(a), 1, 0, AW'(a), 1);
            chk("R7", 4'b1110);
            drive(1, AW'(a), 1, 1, AW'(a), 1);
            chk("R7", 4'b1010);
        end

        // R9 / R10: slave mode, matching addresses, all busy inputs and write requests
        drive(0, '0, 0, 0, '0, 0);
        is_master = 0;
        for (int c = 0; c < 16; c++) begin
            logic bl, br, wl, wr;
            bl = c[0]; br = c[1]; wl = c[2]; wr = c[3];
            @(negedge clk);
            lt_busy_in_n = bl; rt_busy_in_n = br;
            lt_en = 1; rt_en = 1; lt_addr = 3'd5; rt_addr = 3'd5;
            lt_wr = wl; rt_wr = wr;
            #1;
            chk((bl && br) ? "R10" : "R9", {2'b11, wl && bl, wr && br});
        end
        lt_busy_in_n = 1; rt_busy_in_n = 1;
        // R8: back to master mode, busy inputs ignored; fresh tie goes left
        drive(0, '0, 0, 0, '0, 0);
        is_master = 1;
        lt_busy_in_n = 0; rt_busy_in_n = 0;
        drive(1, 3'd2, 1, 1, 3'd2, 1);
        chk("R8", 4'b1010);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule